// File: doc/BRIEF.md
# Supply Warning Interrupt and Reset Stretcher

This block is the digital control that sits behind two supply-monitor comparators. One comparator watches the core supply rail. The other watches an external sense pin. A select input picks which comparator drives a warning flag. Every change of that flag, up or down, marks an interrupt as pending. The interrupt request reaches the processor only while the enable input is high. A one-cycle acknowledge clears the pending mark.

The block also stretches a low-voltage reset request. While the request is active, and for a fixed number of cycles after it clears, the system reset output stays high. The number is 256 or 4096 cycles, picked by an option input. Flag changes during that window are not recorded as events. When the window ends, the pending mark takes the flag's current value. Software that enables the interrupt while the supply is still low therefore gets one request at once, and a second one when the supply recovers.

Top module: `vdet_seq`

## Requirements
- R1: While `rst_n` is low, `sys_rst_o` is 1, `warn_flag_o` is 1 and the pending mark is 1.
- R2: With `src_sel_i` = 0 the flag follows `supply_cmp_i`; with 1 it follows `ext_cmp_i` (1 = below threshold). A comparator change shows on `warn_flag_o` after two rising clock edges, not after one.
- R3: Outside reset, a flag change in either direction sets the pending mark. `irq_o` shows it after the third rising edge that follows the input change.
- R4: `irq_o` is the pending mark gated by `irq_en_i`. While the enable is 0 the request is held back but not lost, and raising the enable shows it at once.
- R5: `sys_rst_o` rises one edge after `lvr_req_i` is seen high. It stays high while the request is high. It falls after exactly 256 edges with the request low when `long_dly_i` = 0, and after 4096 such edges when it is 1.
- R6: Flag changes while `sys_rst_o` is high create no event. When `sys_rst_o` falls, the pending mark equals the flag.
- R7: A cycle with `irq_ack_i` high and no flag change clears the pending mark.
- R8: When a flag change and `irq_ack_i` fall in the same cycle, the mark stays set.
- R9: A change of `src_sel_i` creates no event, even when the new source holds a different level.
- R10: Several causes that arrive while the enable is low merge into one request. After it is acknowledged, `irq_o` stays low until the next flag change.

Where one requirement describes a window, the bench samples it at its boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| supply_cmp_i | input | 1 | Raw supply comparator, 1 = supply below warning level |
| ext_cmp_i | input | 1 | Raw external pin comparator, 1 = below level |
| lvr_req_i | input | 1 | Low-voltage reset request, level |
| src_sel_i | input | 1 | Flag source: 0 supply, 1 external pin |
| irq_en_i | input | 1 | Interrupt enable |
| long_dly_i | input | 1 | Reset stretch: 0 = 256 cycles, 1 = 4096 cycles |
| irq_ack_i | input | 1 | One-cycle interrupt acknowledge |
| sys_rst_o | output | 1 | Stretched system reset |
| warn_flag_o | output | 1 | Warning flag from the selected comparator |
| irq_o | output | 1 | Interrupt request |

## Verification
Two things can land on the same cycle: an acknowledge from software and a new flag change that the edge detector reports. The bench lines them up on purpose. It changes the supply comparator input, counts two edges through the synchroniser, and raises the acknowledge in the cycle when the edge detector fires. It then expects `irq_o` to stay high, because the new event must not be lost. The same check runs against a lone acknowledge, which must clear the request, so a priority swap in the pending logic shows up as a mismatch.

// File: rtl/vdet_pkg.sv
package vdet_pkg;

   typedef enum logic {
      SRC_SUPPLY = 1'b0,
      SRC_PIN    = 1'b1
   } vdet_src_e;

   // index of each comparator in the synchroniser bus
   localparam int IDX_SUPPLY = 0;
   localparam int IDX_PIN    = 1;
   localparam int N_CMP      = 2;

endpackage

// File: rtl/vdet_sync.sv
module vdet_sync #(
   parameter int               WIDTH   = 2,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("vdet_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("vdet_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/vdet_rst_stretch.sv
module vdet_rst_stretch #(
   parameter int SHORT_CYC = 256,
   parameter int LONG_CYC  = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvr_req_i,
   input  logic long_dly_i,
   output logic busy_o
);

   localparam int            CW        = $clog2(LONG_CYC);
   localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_CYC - 1);
   localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_CYC - 1);

   generate
      if (SHORT_CYC < 2) begin : g_bad_short
         $error("vdet_rst_stretch: SHORT_CYC must be at least 2");
      end
      if (LONG_CYC <= SHORT_CYC) begin : g_bad_long
         $error("vdet_rst_stretch: LONG_CYC must exceed SHORT_CYC");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   assign lim = long_dly_i ? LONG_LIM : SHORT_LIM;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b1;
         cnt    <= '0;
      end else if (lvr_req_i) begin
         busy_o <= 1'b1;
         cnt    <= '0;
      end else if (busy_o) begin
         if (cnt == lim) busy_o <= 1'b0;
         else            cnt    <= cnt + 1'b1;
      end
   end

   // R5: a request is always answered by reset on the next cycle
   a_r5_req_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
      lvr_req_i |=> busy_o);

   // R5: reset may only end after a cycle with the request low
   a_r5_release_needs_low_req: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> !$past(lvr_req_i));

endmodule

// File: rtl/vdet_edge_pend.sv
module vdet_edge_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic flag_i,
   input  logic sel_i,
   input  logic busy_i,
   input  logic ack_i,
   output logic pend_o
);

   logic prev_flag;
   logic sel_q;
   logic edge_ev;

   // a source switch masks the apparent level change in that cycle
   assign edge_ev = (flag_i ^ prev_flag) & ~(sel_i ^ sel_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_flag <= 1'b1;
         sel_q     <= 1'b0;
         pend_o    <= 1'b1;
      end else begin
         prev_flag <= flag_i;
         sel_q     <= sel_i;
         if (busy_i)       pend_o <= flag_i;
         else if (edge_ev) pend_o <= 1'b1;
         else if (ack_i)   pend_o <= 1'b0;
      end
   end

   // R3: a level change on an unchanged source marks the interrupt
   a_r3_change_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && flag_i != $past(flag_i) && sel_i == $past(sel_i)) |=> pend_o);

   // R6: the pending mark mirrors the flag when reset ends
   a_r6_seed_at_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_i) |-> (pend_o == $past(flag_i)));

   // R7: a lone acknowledge clears the mark
   a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && ack_i && !edge_ev) |=> !pend_o);

   // R8: a fresh event beats a coincident acknowledge
   a_r8_event_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && ack_i && edge_ev) |=> pend_o);

   // R9: switching the source leaves the mark alone
   a_r9_switch_no_event: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && sel_i != sel_q && !ack_i) |=> (pend_o == $past(pend_o)));

endmodule

// File: rtl/vdet_seq.sv
module vdet_seq
   import vdet_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int SHORT_CYC   = 256,
   parameter int LONG_CYC    = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_cmp_i,
   input  logic ext_cmp_i,
   input  logic lvr_req_i,
   input  logic src_sel_i,
   input  logic irq_en_i,
   input  logic long_dly_i,
   input  logic irq_ack_i,
   output logic sys_rst_o,
   output logic warn_flag_o,
   output logic irq_o
);

   logic [N_CMP-1:0] cmp_raw;
   logic [N_CMP-1:0] cmp_s;
   logic             busy;
   logic             pend;
   vdet_src_e        src;

   assign cmp_raw[IDX_SUPPLY] = supply_cmp_i;
   assign cmp_raw[IDX_PIN]    = ext_cmp_i;
   assign src = vdet_src_e'(src_sel_i);

   vdet_sync #(
      .WIDTH   (N_CMP),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({N_CMP{1'b1}})
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cmp_raw),
      .q_o   (cmp_s)
   );

   assign warn_flag_o = (src == SRC_PIN) ? cmp_s[IDX_PIN] : cmp_s[IDX_SUPPLY];

   vdet_rst_stretch #(
      .SHORT_CYC (SHORT_CYC),
      .LONG_CYC  (LONG_CYC)
   ) u_stretch (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvr_req_i  (lvr_req_i),
      .long_dly_i (long_dly_i),
      .busy_o     (busy)
   );

   vdet_edge_pend u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag_i (warn_flag_o),
      .sel_i  (src_sel_i),
      .busy_i (busy),
      .ack_i  (irq_ack_i),
      .pend_o (pend)
   );

   assign sys_rst_o = busy;
   assign irq_o     = pend & irq_en_i;

   // R4: an enabled request stays up until acknowledged
   a_r4_request_held: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !irq_ack_i && !sys_rst_o && irq_en_i) |=> (pend));

endmodule

// File: tb/vdet_seq_test.sv
`timescale 1ns/1ps
module vdet_seq_test;

   localparam int SHORT_N = 256;
   localparam int LONG_N  = 4096;

   // fields: sel sup ext en ack | exp_flag exp_irq
   localparam logic [6:0] VEC [0:7] = '{
      7'b0001101,
      7'b0101111,
      7'b1101100,
      7'b1111111,
      7'b1100000,
      7'b1101101,
      7'b0101110,
      7'b0001101
   };

   logic clk = 1'b0;
   logic rst_n, supply_cmp, ext_cmp, lvr_req, src_sel, irq_en, long_dly, irq_ack;
   logic sys_rst, warn_flag, irq;
   int   n_tests = 0;
   int   n_fail  = 0;

   always #2 clk = ~clk;

   vdet_seq uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .supply_cmp_i (supply_cmp),
      .ext_cmp_i    (ext_cmp),
      .lvr_req_i    (lvr_req),
      .src_sel_i    (src_sel),
      .irq_en_i     (irq_en),
      .long_dly_i   (long_dly),
      .irq_ack_i    (irq_ack),
      .sys_rst_o    (sys_rst),
      .warn_flag_o  (warn_flag),
      .irq_o        (irq)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic ack_pulse();
      @(negedge clk) irq_ack = 1'b1;
      @(negedge clk) irq_ack = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      rst_n = 1'b0; lvr_req = 1'b1; supply_cmp = 1'b1; ext_cmp = 1'b0;
      src_sel = 1'b0; irq_en = 1'b0; long_dly = 1'b0; irq_ack = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 flag in reset", warn_flag, 1'b1);
      chk("R1 sys reset in reset", sys_rst, 1'b1);
      @(negedge clk) rst_n = 1'b1;
      repeat (3) @(negedge clk);
      lvr_req = 1'b0;
      repeat (SHORT_N + 4) @(negedge clk);
      chk("R5 released after short delay", sys_rst, 1'b0);
      chk("R4 seeded request masked", irq, 1'b0);
      @(negedge clk) irq_en = 1'b1;
      #1 chk("R1/R6 seeded request on enable", irq, 1'b1);
      ack_pulse();
      chk("R7 ack clears", irq, 1'b0);

      // table walk: source select, both edges, masking
      for (int v = 0; v < 8; v++) begin
         @(negedge clk);
         src_sel    = VEC[v][6];
         supply_cmp = VEC[v][5];
         ext_cmp    = VEC[v][4];
         irq_en     = VEC[v][3];
         repeat (4) @(negedge clk);
         chk($sformatf("R2 flag vec %0d", v), warn_flag, VEC[v][1]);
         chk($sformatf("R3/R4/R9 irq vec %0d", v), irq, VEC[v][0]);
         if (VEC[v][2]) ack_pulse();
      end

      // R2 synchroniser depth and R3 latency
      @(negedge clk) supply_cmp = 1'b1;
      @(negedge clk) chk("R2 flag after one edge", warn_flag, 1'b0);
      @(negedge clk) chk("R2 flag after two edges", warn_flag, 1'b1);
      chk("R3 irq after two edges", irq, 1'b0);
      @(negedge clk) chk("R3 irq after three edges", irq, 1'b1);
      ack_pulse();

      // R8 acknowledge in the same cycle as a new event
      @(negedge clk) supply_cmp = 1'b0;
      @(negedge clk);
      @(negedge clk) irq_ack = 1'b1;
      @(negedge clk) irq_ack = 1'b0;
      chk("R8 event wins over ack", irq, 1'b1);
      ack_pulse();
      chk("R7 ack clears after R8", irq, 1'b0);

      // R10 two crossings while disabled merge into one request
      @(negedge clk) irq_en = 1'b0; supply_cmp = 1'b1;
      repeat (5) @(negedge clk);
      supply_cmp = 1'b0;
      repeat (5) @(negedge clk);
      chk("R10 masked while disabled", irq, 1'b0);
      irq_en = 1'b1;
      #1 chk("R10 late enable shows request", irq, 1'b1);
      ack_pulse();
      repeat (20) @(negedge clk);
      chk("R10 single request only", irq, 1'b0);

      // R5 / R6 short stretch with edges suppressed
      @(negedge clk) lvr_req = 1'b1;
      @(negedge clk) chk("R5 reset follows request", sys_rst, 1'b1);
      repeat (4) @(negedge clk);
      lvr_req = 1'b0;
      for (int i = 1; i < SHORT_N; i++) begin
         @(negedge clk);
         if (i == 10) supply_cmp = 1'b1;
         if (i == 40) supply_cmp = 1'b0;
      end
      chk("R5 held one cycle before short limit", sys_rst, 1'b1);
      @(negedge clk) chk("R5 released at short limit", sys_rst, 1'b0);
      chk("R6 edges in stretch suppressed", irq, 1'b0);
      chk("R6 flag low at release", warn_flag, 1'b0);

      // R5 / R6 long stretch, supply still low at release
      @(negedge clk) long_dly = 1'b1; lvr_req = 1'b1; supply_cmp = 1'b1;
      repeat (3) @(negedge clk);
      lvr_req = 1'b0;
      repeat (LONG_N - 1) @(negedge clk);
      chk("R5 held one cycle before long limit", sys_rst, 1'b1);
      @(negedge clk) chk("R5 released at long limit", sys_rst, 1'b0);
      chk("R6 seeded request at release", irq, 1'b1);
      chk("R6 flag high at release", warn_flag, 1'b1);
      ack_pulse();
      chk("R7 ack after release", irq, 1'b0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule